// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge Wait

This block moves one I2C byte and its acknowledge bit between a host register interface and the serial data line. SCL edges come from outside as single-cycle strobes: a rising-edge strobe samples SDA and a falling-edge strobe advances to the next bit. The block drives SDA low when needed and can ask for SCL to be held low. Start and stop generation, arbitration, clock division and pad drivers sit elsewhere.

A mode register sets the bit order, the number of data bits and whether a wait is inserted. When the wait is on, the block stops after the final data bit with SCL held low and raises its interrupt request. It continues to the acknowledge bit only after the host clears that request. The mode register and a slave-address register share one host address, and the interface-enable bit selects which one is reached. In slave receive mode the address register also selects the format. In addressing format the first byte is compared with the stored address, and a mismatching transfer is ignored.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset the control, status and received-data registers read 0x00, the slave-address register reads 0x00, the mode register reads 0x38, and `sda_low`, `scl_hold` and `irq` are all 0. Host map: address 0 is the shared mode/slave-address register, 1 is control (bit0 enable, bit1 transmit, bit2 acknowledge value to send, bit3 slave), 2 is data (a write arms a transfer, a read returns the received byte), and 3 is status (bit0 interrupt request, bit1 busy, bit2 acknowledge received, bit3 waiting).
- R2: Mode bit 7 sets the bit order. At 0 the bits go out from the highest used position down, and at 1 they go out from bit 0 upward. In transmit mode, while a data bit is current, `sda_low` is the inverse of that data bit.
- R3: Mode bits 2:0 give the number of data bits N. Code 000 gives 8, and codes 001 to 111 give 1 to 7. The used positions are bits N-1:0 of the data word.
- R4: With mode bit 6 at 1, the falling strobe of the final data bit starts a wait. `scl_hold` and `irq` become 1, SDA is released, and status bit3 reads 1.
- R5: A wait ends only when the host writes 0 to status bit0. On the next cycle `scl_hold` drops and the acknowledge bit becomes current.
- R6: With mode bit 6 at 0, the acknowledge bit is current directly after the falling strobe of the final data bit, with no hold.
- R7: The falling strobe of the acknowledge bit ends the byte, sets `irq` and clears busy. Writing 1 to status bit0 does not change `irq`, and writing 0 clears it.
- R8: While enable is 1, address 0 reads and writes the mode register. While enable is 0, it reaches the slave-address register, and the mode register keeps its value.
- R9: Mode bits 5:3 always read 1, and writes to them are ignored.
- R10: In receive mode, SDA is stored into the current data position at each rising strobe. During the acknowledge bit `sda_low` is the inverse of control bit2. The byte can be read at address 2 after the transfer.
- R11: In slave receive with slave-address bit0 at 0, the first byte after a control write is checked: its bits 7:1 are compared with address bits 7:1. On a mismatch the block does not drive the acknowledge and does not set `irq`. Data writes are ignored until control is written again.
- R12: With slave-address bit0 at 1, no comparison is made and the acknowledge is driven as in R10.
- R13: In transmit mode, SDA sampled at the acknowledge bit's rising strobe is held in status bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 2 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| scl_rise | input | 1 | Single-cycle strobe on SCL rising edge |
| scl_fall | input | 1 | Single-cycle strobe on SCL falling edge |
| sda_in | input | 1 | Sampled SDA level |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_hold | output | 1 | 1 requests SCL held low (wait) |
| irq | output | 1 | Interrupt request flag |

## Verification
The bench drives transfers in both bit orders, at full and short bit counts, with and without the wait, and compares the line outputs and the request flag with its model on every clock. A design with the order reversed or the count encoding off by one sends the wrong bit at some position. A design that leaves the wait early, or ignores the host clear, shows `scl_hold` at the wrong time. The shared address is checked from both sides, so a mode write that leaks through while the interface is disabled shows up on read-back. The address check is run with a match, a mismatch and non-addressing format; a design that acknowledges on a mismatch, or accepts later data writes, is caught by the SDA compare and by the status read.

// File: rtl/i2cbs_pkg.sv
`timescale 1ns/1ps
package i2cbs_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] A_SHARED = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_DATA   = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_WAIT, PH_ACK} phase_t;
endpackage

// File: rtl/i2cbs_regs.sv
`timescale 1ns/1ps
module i2cbs_regs
  import i2cbs_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             irq_set,
  input  logic             busy,
  input  logic             waiting,
  input  logic             ack_rx,
  input  logic [REG_W-1:0] rx_data,
  output logic             if_en,
  output logic             xmit,
  output logic             ack_val,
  output logic             slave,
  output logic             lsb_first,
  output logic             wait_en,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [REG_W-1:0] sar,
  output logic             irq,
  output logic             go,
  output logic             ctrl_wr
);
  localparam int PAD_W = REG_W - 2 - CNT_W;

  logic [REG_W-1:0] mode_rd;
  logic [REG_W-1:0] rd_next;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign go      = bus_wr && (bus_addr == A_DATA) && if_en;
  assign mode_rd = {lsb_first, wait_en, {PAD_W{1'b1}}, bit_cnt};

  always_comb begin
    case (bus_addr)
      A_SHARED: rd_next = if_en ? mode_rd : sar;
      A_CTRL:   rd_next = {4'b0, slave, ack_val, xmit, if_en};
      A_DATA:   rd_next = rx_data;
      default:  rd_next = {4'b0, waiting, ack_rx, busy, irq};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_en     <= 1'b0;
      xmit      <= 1'b0;
      ack_val   <= 1'b0;
      slave     <= 1'b0;
      lsb_first <= 1'b0;
      wait_en   <= 1'b0;
      bit_cnt   <= '0;
      sar       <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_next;
      if (irq_set)
        irq <= 1'b1;
      else if (bus_wr && bus_addr == A_STAT && !bus_wdata[0])
        irq <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: begin
            if_en   <= bus_wdata[0];
            xmit    <= bus_wdata[1];
            ack_val <= bus_wdata[2];
            slave   <= bus_wdata[3];
          end
          A_SHARED: begin
            if (if_en) begin
              lsb_first <= bus_wdata[REG_W-1];
              wait_en   <= bus_wdata[REG_W-2];
              bit_cnt   <= bus_wdata[CNT_W-1:0];
            end else begin
              sar <= bus_wdata;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_MODE_GATED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_SHARED && !if_en) |=> $stable({lsb_first, wait_en, bit_cnt})); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STAT && !bus_wdata[0] && !irq_set) |=> !irq); // R7
endmodule

// File: rtl/i2cbs_seq.sv
`timescale 1ns/1ps
module i2cbs_seq
  import i2cbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xmit,
  input  logic              ack_val,
  input  logic              slave,
  input  logic              lsb_first,
  input  logic              wait_en,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [DATA_W-1:0] sar,
  input  logic              irq,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  output logic              irq_set,
  output logic              busy,
  output logic              waiting,
  output logic              ack_rx,
  output logic [DATA_W-1:0] rx_data,
  output logic              sda_low,
  output logic              scl_hold
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DATA_W);
  localparam logic [IDX_W:0] ONE      = (IDX_W+1)'(1);

  phase_t            ph_q;
  logic [IDX_W-1:0]  k_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              first_q;
  logic              ign_q;
  logic              ack_q;

  logic [IDX_W:0]    nbits;
  logic [IDX_W:0]    pos_w;
  logic [IDX_W-1:0]  pos;
  logic              last;
  logic              addr_chk;
  logic              mismatch;

  assign nbits    = (bit_cnt == '0) ? FULL_CNT : (IDX_W+1)'(bit_cnt);
  assign pos_w    = lsb_first ? {1'b0, k_q} : (nbits - ONE - {1'b0, k_q});
  assign pos      = pos_w[IDX_W-1:0];
  assign last     = ({1'b0, k_q} == (nbits - ONE));
  assign addr_chk = first_q && slave && !xmit && !sar[0];
  assign mismatch = addr_chk && (rx_q[DATA_W-1:1] != sar[DATA_W-1:1]);

  assign irq_set  = (ph_q == PH_DATA && scl_fall && last && !mismatch && wait_en)
                 || (ph_q == PH_ACK && scl_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      k_q     <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      first_q <= 1'b0;
      ign_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (go && !ign_q) begin
            ph_q <= PH_DATA;
            k_q  <= '0;
            tx_q <= wdata;
            rx_q <= '0;
          end
        end
        PH_DATA: begin
          if (scl_rise && !xmit) rx_q[pos] <= sda_in;
          if (scl_fall) begin
            if (last) begin
              if (mismatch) begin
                ph_q    <= PH_IDLE;
                ign_q   <= 1'b1;
                first_q <= 1'b0;
              end else begin
                ph_q <= wait_en ? PH_WAIT : PH_ACK;
              end
            end else begin
              k_q <= k_q + 1'b1;
            end
          end
        end
        PH_WAIT: if (!irq) ph_q <= PH_ACK;
        default: begin
          if (scl_rise && xmit) ack_q <= sda_in;
          if (scl_fall) begin
            ph_q    <= PH_IDLE;
            first_q <= 1'b0;
          end
        end
      endcase
      if (ctrl_wr) begin
        first_q <= 1'b1;
        ign_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    sda_low = 1'b0;
    if (ph_q == PH_DATA && xmit)       sda_low = ~tx_q[pos];
    else if (ph_q == PH_ACK && !xmit)  sda_low = ~ack_val;
  end

  assign scl_hold = (ph_q == PH_WAIT);
  assign waiting  = (ph_q == PH_WAIT);
  assign busy     = (ph_q != PH_IDLE);
  assign ack_rx   = ack_q;
  assign rx_data  = rx_q;

  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && !irq) |=> (ph_q == PH_ACK)); // R5
  AST_NO_WAIT_ACK: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && scl_fall && last && !mismatch && !wait_en) |=> (ph_q == PH_ACK)); // R6
  AST_IGNORED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ign_q |-> (!sda_low && !busy)); // R11
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ACK && scl_fall) |=> !busy); // R7
endmodule

// File: rtl/i2c_byte_shifter.sv
`timescale 1ns/1ps
module i2c_byte_shifter
  import i2cbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  output logic              sda_low,
  output logic              scl_hold,
  output logic              irq
);
  logic             if_en, xmit, ack_val, slave, lsb_first, wait_en;
  logic [CNT_W-1:0] bit_cnt;
  logic [REG_W-1:0] sar;
  logic             go, ctrl_wr, irq_set, busy, waiting, ack_rx;
  logic [REG_W-1:0] rx_data;

  i2cbs_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set),
    .busy(busy), .waiting(waiting), .ack_rx(ack_rx), .rx_data(rx_data),
    .if_en(if_en), .xmit(xmit), .ack_val(ack_val), .slave(slave),
    .lsb_first(lsb_first), .wait_en(wait_en), .bit_cnt(bit_cnt), .sar(sar),
    .irq(irq), .go(go), .ctrl_wr(ctrl_wr)
  );

  i2cbs_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst), .go(go), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .xmit(xmit), .ack_val(ack_val), .slave(slave), .lsb_first(lsb_first),
    .wait_en(wait_en), .bit_cnt(bit_cnt), .sar(sar), .irq(irq),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .irq_set(irq_set), .busy(busy), .waiting(waiting), .ack_rx(ack_rx),
    .rx_data(rx_data), .sda_low(sda_low), .scl_hold(scl_hold)
  );

  AST_WAIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold) |-> irq); // R4
  AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (rst)
    (scl_hold && !irq) |=> !scl_hold); // R5
endmodule

// File: tb/i2c_byte_shifter_tb.sv
`timescale 1ns/1ps
module i2c_byte_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
  logic       sda_low, scl_hold, irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    live = 1'b0;
  bit    exp_sda = 1'b0, exp_hold = 1'b0, exp_irq = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  i2c_byte_shifter dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_in(sda_in), .sda_low(sda_low),
    .scl_hold(scl_hold), .irq(irq)
  );

  // per-clock comparison against the behavioural expectation
  always @(negedge clk) begin
    if (live) begin
      n_chk++;
      if (sda_low !== exp_sda || scl_hold !== exp_hold || irq !== exp_irq) begin
        n_fail++;
        $display("FAIL %s line compare: sda_low=%0b scl_hold=%0b irq=%0b expected %0b %0b %0b",
                 tag, sda_low, scl_hold, irq, exp_sda, exp_hold, exp_irq);
      end
    end
  end

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic rise(input logic v);
    @(posedge clk); #1;
    sda_in = v; scl_rise = 1'b1;
    @(posedge clk); #1;
    scl_rise = 1'b0;
  endtask

  task automatic fall();
    @(posedge clk); #1;
    scl_fall = 1'b1;
    @(posedge clk); #1;
    scl_fall = 1'b0;
  endtask

  function automatic int bit_pos(input int k, input int n, input bit lsb);
    return lsb ? k : n - 1 - k;
  endfunction

  // wait phase: check status, clear request, expect release one cycle later
  task automatic wait_phase(input bit ack_drive);
    logic [7:0] s;
    tag = "R4"; exp_sda = 1'b0; exp_hold = 1'b1; exp_irq = 1'b1;
    rd(2'd3, s);
    chk("R4 status during wait", s & 8'h0B, 8'h0B);
    wr(2'd3, 8'h01);                 // R7: writing 1 leaves the request set
    tag = "R5";
    wr(2'd3, 8'h00);
    exp_irq = 1'b0;
    @(posedge clk); #1;
    exp_hold = 1'b0; exp_sda = ack_drive;
  endtask

  task automatic tx_byte(input logic [7:0] d, input int n, input bit lsb,
                         input bit wt, input logic ackin);
    logic [7:0] s;
    tag = "R2";
    wr(2'd2, d);
    for (int k = 0; k < n; k++) begin
      exp_sda = ~d[bit_pos(k, n, lsb)];
      rise(1'b1);
      fall();
    end
    exp_sda = 1'b0;
    if (wt) wait_phase(1'b0);
    tag = "R6";
    rise(ackin);
    fall();
    exp_irq = 1'b1;
    rd(2'd3, s);
    chk("R13 acknowledge captured, R7 end of byte", s & 8'h07, {5'b0, ackin, 2'b01});
    tag = "R7";
    wr(2'd3, 8'h00);
    exp_irq = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input int n, input bit lsb,
                         input bit wt, input bit ackv, input bit match);
    logic [7:0] s;
    int mask;
    mask = (1 << n) - 1;
    tag = "R10";
    exp_sda = 1'b0;
    wr(2'd2, 8'h00);
    for (int k = 0; k < n; k++) begin
      rise(d[bit_pos(k, n, lsb)]);
      fall();
    end
    if (!match) begin
      tag = "R11";
      rise(1'b1);
      fall();
      rd(2'd3, s);
      chk("R11 mismatch leaves no request", s & 8'h0B, 8'h00);
      return;
    end
    if (wt) wait_phase(~ackv);
    else exp_sda = ~ackv;
    tag = "R10";
    rise(1'b1);
    fall();
    exp_sda = 1'b0; exp_irq = 1'b1;
    rd(2'd2, s);
    chk("R10 received byte", s, d & mask[7:0]);
    wr(2'd3, 8'h00);
    exp_irq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    live = 1'b1;
    // R1 reset state
    rd(2'd1, v); chk("R1 control after reset", v, 8'h00);
    rd(2'd3, v); chk("R1 status after reset", v, 8'h00);
    rd(2'd0, v); chk("R1 slave address after reset", v, 8'h00);
    rd(2'd2, v); chk("R1 data after reset", v, 8'h00);
    wr(2'd1, 8'h03);
    rd(2'd0, v); chk("R1 mode after reset", v, 8'h38);
    // R9 unused bits
    wr(2'd0, 8'hC5); rd(2'd0, v); chk("R9 unused bits read one", v, 8'hFD);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R9 write of zeros", v, 8'h38);
    // R2 / R6 transmit both orders, no wait
    tx_byte(8'hB1, 8, 1'b0, 1'b0, 1'b0);
    wr(2'd0, 8'h80);
    tx_byte(8'hB1, 8, 1'b1, 1'b0, 1'b0);
    // R3 short counts
    wr(2'd0, 8'h03);
    tx_byte(8'h05, 3, 1'b0, 1'b0, 1'b0);
    wr(2'd0, 8'h81);
    tx_byte(8'h01, 1, 1'b1, 1'b0, 1'b0);
    // R4 / R5 wait insertion, R13 not-acknowledge seen
    wr(2'd0, 8'h40);
    tx_byte(8'h3C, 8, 1'b0, 1'b1, 1'b1);
    // R10 receive
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h00);
    rx_byte(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    wr(2'd0, 8'hC5);
    rx_byte(8'h13, 5, 1'b1, 1'b1, 1'b0, 1'b1);
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h00);
    rx_byte(8'h6A, 8, 1'b0, 1'b0, 1'b1, 1'b1);
    // R8 shared address gating
    tag = "R8";
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hB4);
    rd(2'd0, v); chk("R8 disabled reaches slave address", v, 8'hB4);
    wr(2'd1, 8'h01);
    rd(2'd0, v); chk("R8 mode kept while disabled", v, 8'h38);
    // R11 addressing format
    wr(2'd1, 8'h09);
    rx_byte(8'hB5, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    wr(2'd1, 8'h09);
    rx_byte(8'h40, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(2'd2, 8'h00);
    rd(2'd3, v); chk("R11 data write ignored after mismatch", v & 8'h0B, 8'h00);
    // R12 non-addressing format
    tag = "R12";
    wr(2'd1, 8'h08);
    wr(2'd0, 8'hB5);
    wr(2'd1, 8'h09);
    rx_byte(8'h40, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule